// File: doc/BRIEF.md
# Physical address to DRAM bank/row/column mapper

This block splits a physical address into a DRAM bank number, a row number and a column offset within the row. It supports four selectable placements. Cache-line interleaving spreads consecutive cache lines across banks. Page interleaving keeps whole rows together and steps banks once per row. A bit-exchange variant swaps low cache-tag bits with the high column bits before page interleaving. The XOR-permuted variant keeps page interleaving's row and column, but folds the low cache-tag bits into the bank bits by XOR. With the XOR variant, addresses that collide in the same cache set land in different banks, and every row stays whole.

A request carries an address and a 2-bit scheme code. The scheme code is captured in the same cycle as the address. The translated triple appears, registered and valid-qualified, one cycle later. A second, independent port performs the inverse translation: it rebuilds the address from a bank, a row, a column offset and a scheme code, also with one cycle of latency. It exists so that mappings can be checked end to end.

Widths are parameters: the address, the cache block offset, the column (page) offset, the bank field, the cache set index and the number of exchanged bits. The cache tag starts at `ADDR_W - (ADDR_W - SET_W - BLK_OFF_W)`, which is `SET_W + BLK_OFF_W`. Elaboration stops if the tag does not start above the bank field, or if the tag is narrower than the bank field.

Top module: `addr_map_xor`

## Requirements
- R1: While rst_ni is low, out_valid_o and inv_valid_o are 0.
- R2: out_valid_o equals in_valid_i of the previous cycle. In a cycle after in_valid_i was 0, the bank, row and offset outputs keep their previous values.
- R3: Scheme code 0 (cache line): bank = address bits [BLK_OFF_W +: BANK_W]. The remaining address bits are closed up with their order kept; the low PAGE_OFF_W of them form the offset and the rest form the row.
- R4: Scheme code 1 (page): offset = address [PAGE_OFF_W-1:0]; bank = address [PAGE_OFF_W +: BANK_W]; row = the bits above the bank field.
- R5: Scheme code 2 (swap): the SWAP_W address bits starting at the tag start position are exchanged with the top SWAP_W bits of the page offset field. The result is then mapped as in R4.
- R6: Scheme code 3 (permute): bank bit i = address bit (PAGE_OFF_W+i) XOR address bit (tag start + i), for i from 0 to BANK_W-1. Row and offset are as in R4.
- R7: Under scheme code 3, every address within one aligned 2^PAGE_OFF_W-byte page maps to the same bank and row.
- R8: inv_valid_o equals inv_valid_i of the previous cycle. inv_addr_o is the address that the forward mapping of inv_scheme_i would send to the supplied bank, row and offset.
- R9: For every scheme, feeding a forward result into the inverse port returns the original address.
- R10: The scheme code is taken only in cycles with in_valid_i high. Changing it while in_valid_i is low leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Forward request valid |
| in_scheme_i | input | 2 | Forward scheme code (0 line, 1 page, 2 swap, 3 permute) |
| in_addr_i | input | ADDR_W | Physical address |
| out_valid_o | output | 1 | Forward result valid |
| out_bank_o | output | BANK_W | Bank number |
| out_row_o | output | ADDR_W-PAGE_OFF_W-BANK_W | Row number |
| out_off_o | output | PAGE_OFF_W | Column offset within the row |
| inv_valid_i | input | 1 | Inverse request valid |
| inv_scheme_i | input | 2 | Inverse scheme code |
| inv_bank_i | input | BANK_W | Bank number to invert |
| inv_row_i | input | ADDR_W-PAGE_OFF_W-BANK_W | Row number to invert |
| inv_off_i | input | PAGE_OFF_W | Column offset to invert |
| inv_valid_o | output | 1 | Inverse result valid |
| inv_addr_o | output | ADDR_W | Rebuilt address |

## Verification
The assertions assume the inputs are known whenever a valid is high. They also assume the parameters satisfy the elaboration checks, so that the tag field lies wholly above the bank field. The bench uses a reduced configuration: 12-bit addresses, 4 banks and 8-byte rows. Every address is swept under every scheme code, so only legal, fully defined inputs reach the block. Each forward result is fed back through the inverse port. This exercises the round trip over the whole address space rather than over a sample.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;
  typedef enum logic [1:0] {
    SCH_LINE = 2'd0,
    SCH_PAGE = 2'd1,
    SCH_SWAP = 2'd2,
    SCH_PERM = 2'd3
  } scheme_e;
endpackage

// File: rtl/addr_map_swap.sv
// Exchanges two equal-width, non-overlapping bit fields of an address.
module addr_map_swap #(
  parameter int ADDR_W = 32,
  parameter int LO_POS = 8,
  parameter int HI_POS = 20,
  parameter int FLD_W  = 3
) (
  input  logic [ADDR_W-1:0] a_i,
  output logic [ADDR_W-1:0] a_o
);
  if (FLD_W == 0) begin : g_pass
    assign a_o = a_i;
  end else begin : g_swap
    always_comb begin
      a_o = a_i;
      a_o[LO_POS +: FLD_W] = a_i[HI_POS +: FLD_W];
      a_o[HI_POS +: FLD_W] = a_i[LO_POS +: FLD_W];
    end
  end
endmodule

// File: rtl/addr_map_fwd.sv
module addr_map_fwd
  import addr_map_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_OFF_W  = 6,
  parameter int PAGE_OFF_W = 11,
  parameter int BANK_W     = 5,
  parameter int SET_W      = 14,
  parameter int SWAP_W     = 3,
  localparam int TAG_W     = ADDR_W - SET_W - BLK_OFF_W,
  localparam int TAG_LSB   = ADDR_W - TAG_W,
  localparam int ROW_W     = ADDR_W - PAGE_OFF_W - BANK_W,
  localparam int REST_W    = ADDR_W - BANK_W
) (
  input  scheme_e               scheme_i,
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [BANK_W-1:0]     bank_o,
  output logic [ROW_W-1:0]      row_o,
  output logic [PAGE_OFF_W-1:0] off_o
);
  logic [ADDR_W-1:0] addr_sw;
  logic [ADDR_W-1:0] addr_sel;
  logic [REST_W-1:0] rest;

  addr_map_swap #(
    .ADDR_W(ADDR_W), .LO_POS(PAGE_OFF_W - SWAP_W), .HI_POS(TAG_LSB), .FLD_W(SWAP_W)
  ) i_swap (
    .a_i(addr_i),
    .a_o(addr_sw)
  );

  // Remove the bank field at pos and close the gap.
  function automatic logic [REST_W-1:0] drop_fld(input logic [ADDR_W-1:0] a, input int pos);
    logic [REST_W-1:0] r;
    for (int i = 0; i < REST_W; i++) r[i] = (i < pos) ? a[i] : a[i+BANK_W];
    return r;
  endfunction

  always_comb begin
    addr_sel = (scheme_i == SCH_SWAP) ? addr_sw : addr_i;
    if (scheme_i == SCH_LINE) begin
      bank_o = addr_sel[BLK_OFF_W +: BANK_W];
      rest   = drop_fld(addr_sel, BLK_OFF_W);
    end else begin
      bank_o = addr_sel[PAGE_OFF_W +: BANK_W];
      rest   = drop_fld(addr_sel, PAGE_OFF_W);
      if (scheme_i == SCH_PERM) bank_o = bank_o ^ addr_sel[TAG_LSB +: BANK_W];
    end
    off_o = rest[PAGE_OFF_W-1:0];
    row_o = rest[REST_W-1:PAGE_OFF_W];
  end
endmodule

// File: rtl/addr_map_inv.sv
module addr_map_inv
  import addr_map_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_OFF_W  = 6,
  parameter int PAGE_OFF_W = 11,
  parameter int BANK_W     = 5,
  parameter int SET_W      = 14,
  parameter int SWAP_W     = 3,
  localparam int TAG_W     = ADDR_W - SET_W - BLK_OFF_W,
  localparam int TAG_LSB   = ADDR_W - TAG_W,
  localparam int ROW_W     = ADDR_W - PAGE_OFF_W - BANK_W,
  localparam int REST_W    = ADDR_W - BANK_W
) (
  input  scheme_e               scheme_i,
  input  logic [BANK_W-1:0]     bank_i,
  input  logic [ROW_W-1:0]      row_i,
  input  logic [PAGE_OFF_W-1:0] off_i,
  output logic [ADDR_W-1:0]     addr_o
);
  logic [REST_W-1:0] rest;
  logic [BANK_W-1:0] bank_orig;
  logic [ADDR_W-1:0] addr_pg;
  logic [ADDR_W-1:0] addr_unsw;

  // Reopen a BANK_W gap at pos and place the bank bits there.
  function automatic logic [ADDR_W-1:0] ins_fld(input logic [REST_W-1:0] r,
                                                input logic [BANK_W-1:0] b, input int pos);
    logic [ADDR_W-1:0] a;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i < pos)               a[i] = r[i];
      else if (i < pos + BANK_W) a[i] = b[i-pos];
      else                       a[i] = r[i-BANK_W];
    end
    return a;
  endfunction

  // Tag bits sit above the bank field, so they are untouched and usable for the undo.
  always_comb begin
    rest      = {row_i, off_i};
    bank_orig = bank_i;
    if (scheme_i == SCH_PERM) bank_orig = bank_i ^ rest[TAG_LSB-BANK_W +: BANK_W];
    addr_pg   = ins_fld(rest, bank_orig, PAGE_OFF_W);
  end

  addr_map_swap #(
    .ADDR_W(ADDR_W), .LO_POS(PAGE_OFF_W - SWAP_W), .HI_POS(TAG_LSB), .FLD_W(SWAP_W)
  ) i_unswap (
    .a_i(addr_pg),
    .a_o(addr_unsw)
  );

  always_comb begin
    unique case (scheme_i)
      SCH_LINE: addr_o = ins_fld(rest, bank_i, BLK_OFF_W);
      SCH_SWAP: addr_o = addr_unsw;
      default:  addr_o = addr_pg;
    endcase
  end
endmodule

// File: rtl/addr_map_xor.sv
module addr_map_xor
  import addr_map_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_OFF_W  = 6,
  parameter int PAGE_OFF_W = 11,
  parameter int BANK_W     = 5,
  parameter int SET_W      = 14,
  parameter int SWAP_W     = 3,
  localparam int TAG_W     = ADDR_W - SET_W - BLK_OFF_W,
  localparam int TAG_LSB   = ADDR_W - TAG_W,
  localparam int ROW_W     = ADDR_W - PAGE_OFF_W - BANK_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  in_valid_i,
  input  logic [1:0]            in_scheme_i,
  input  logic [ADDR_W-1:0]     in_addr_i,
  output logic                  out_valid_o,
  output logic [BANK_W-1:0]     out_bank_o,
  output logic [ROW_W-1:0]      out_row_o,
  output logic [PAGE_OFF_W-1:0] out_off_o,
  input  logic                  inv_valid_i,
  input  logic [1:0]            inv_scheme_i,
  input  logic [BANK_W-1:0]     inv_bank_i,
  input  logic [ROW_W-1:0]      inv_row_i,
  input  logic [PAGE_OFF_W-1:0] inv_off_i,
  output logic                  inv_valid_o,
  output logic [ADDR_W-1:0]     inv_addr_o
);
  if (TAG_LSB <= PAGE_OFF_W + BANK_W - 1) begin : g_bad_tag_pos
    $error("tag field must start above the bank field");
  end
  if (TAG_W < BANK_W || TAG_W < SWAP_W) begin : g_bad_tag_w
    $error("tag field narrower than bank or swap field");
  end
  if (SWAP_W > PAGE_OFF_W || BLK_OFF_W > PAGE_OFF_W) begin : g_bad_off
    $error("swap width or block offset exceeds page offset");
  end

  logic [BANK_W-1:0]     f_bank;
  logic [ROW_W-1:0]      f_row;
  logic [PAGE_OFF_W-1:0] f_off;
  logic [ADDR_W-1:0]     i_addr;

  addr_map_fwd #(
    .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W), .PAGE_OFF_W(PAGE_OFF_W),
    .BANK_W(BANK_W), .SET_W(SET_W), .SWAP_W(SWAP_W)
  ) i_fwd (
    .scheme_i(scheme_e'(in_scheme_i)),
    .addr_i  (in_addr_i),
    .bank_o  (f_bank),
    .row_o   (f_row),
    .off_o   (f_off)
  );

  addr_map_inv #(
    .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W), .PAGE_OFF_W(PAGE_OFF_W),
    .BANK_W(BANK_W), .SET_W(SET_W), .SWAP_W(SWAP_W)
  ) i_inv (
    .scheme_i(scheme_e'(inv_scheme_i)),
    .bank_i  (inv_bank_i),
    .row_i   (inv_row_i),
    .off_i   (inv_off_i),
    .addr_o  (i_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_bank_o  <= '0;
      out_row_o   <= '0;
      out_off_o   <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_bank_o <= f_bank;
        out_row_o  <= f_row;
        out_off_o  <= f_off;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_valid_o <= 1'b0;
      inv_addr_o  <= '0;
    end else begin
      inv_valid_o <= inv_valid_i;
      if (inv_valid_i) inv_addr_o <= i_addr;
    end
  end
endmodule

// File: rtl/addr_map_xor_chk.sv
module addr_map_xor_chk #(
  parameter int ADDR_W     = 32,
  parameter int BLK_OFF_W  = 6,
  parameter int PAGE_OFF_W = 11,
  parameter int BANK_W     = 5,
  parameter int SET_W      = 14,
  localparam int TAG_LSB   = SET_W + BLK_OFF_W,
  localparam int ROW_W     = ADDR_W - PAGE_OFF_W - BANK_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  in_valid_i,
  input logic [1:0]            in_scheme_i,
  input logic [ADDR_W-1:0]     in_addr_i,
  input logic                  out_valid_o,
  input logic [BANK_W-1:0]     out_bank_o,
  input logic [ROW_W-1:0]      out_row_o,
  input logic [PAGE_OFF_W-1:0] out_off_o,
  input logic                  inv_valid_i,
  input logic                  inv_valid_o
);
  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && !inv_valid_o));

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r2_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable({out_bank_o, out_row_o, out_off_o}));

  a_r4_page_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_scheme_i == 2'd1) |=>
      (out_off_o == $past(in_addr_i[PAGE_OFF_W-1:0]) &&
       out_bank_o == $past(in_addr_i[PAGE_OFF_W +: BANK_W]) &&
       out_row_o == $past(in_addr_i[ADDR_W-1 -: ROW_W])));

  a_r6_perm_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_scheme_i == 2'd3) |=>
      (out_bank_o == ($past(in_addr_i[PAGE_OFF_W +: BANK_W]) ^ $past(in_addr_i[TAG_LSB +: BANK_W])) &&
       out_off_o == $past(in_addr_i[PAGE_OFF_W-1:0]) &&
       out_row_o == $past(in_addr_i[ADDR_W-1 -: ROW_W])));

  a_r8_inv_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i |=> inv_valid_o);
endmodule

bind addr_map_xor addr_map_xor_chk #(
  .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W), .PAGE_OFF_W(PAGE_OFF_W),
  .BANK_W(BANK_W), .SET_W(SET_W)
) i_addr_map_xor_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_scheme_i(in_scheme_i),
  .in_addr_i(in_addr_i), .out_valid_o(out_valid_o), .out_bank_o(out_bank_o),
  .out_row_o(out_row_o), .out_off_o(out_off_o), .inv_valid_i(inv_valid_i),
  .inv_valid_o(inv_valid_o)
);

// File: tb/test_addr_map_xor.sv
`timescale 1ns/1ps
module test_addr_map_xor;
  // Small configuration: 12-bit address, block offset 1, page offset 3,
  // 4 banks, set index 5 -> tag starts at bit 6, one swapped bit.
  localparam int AW = 12, BOW = 1, POW = 3, BW = 2, SW = 5, XW = 1;
  localparam int RW = AW - POW - BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    in_scheme = '0;
  logic [AW-1:0] in_addr = '0;
  logic          out_valid;
  logic [BW-1:0] out_bank;
  logic [RW-1:0] out_row;
  logic [POW-1:0] out_off;
  logic          inv_valid = 1'b0;
  logic [1:0]    inv_scheme = '0;
  logic [BW-1:0] inv_bank = '0;
  logic [RW-1:0] inv_row = '0;
  logic [POW-1:0] inv_off = '0;
  logic          inv_vo;
  logic [AW-1:0] inv_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_map_xor #(
    .ADDR_W(AW), .BLK_OFF_W(BOW), .PAGE_OFF_W(POW), .BANK_W(BW), .SET_W(SW), .SWAP_W(XW)
  ) i_addr_map_xor (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_scheme_i(in_scheme),
    .in_addr_i(in_addr), .out_valid_o(out_valid), .out_bank_o(out_bank),
    .out_row_o(out_row), .out_off_o(out_off), .inv_valid_i(inv_valid),
    .inv_scheme_i(inv_scheme), .inv_bank_i(inv_bank), .inv_row_i(inv_row),
    .inv_off_i(inv_off), .inv_valid_o(inv_vo), .inv_addr_o(inv_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Arithmetic reference model.
  function automatic void ref_map(input int a, input int s,
                                  output int bank, output int row, output int off);
    int x;
    x = a;
    if (s == 0) begin
      bank = (a >> 1) & 3;
      x = ((a >> 3) << 1) | (a & 1);
      off = x & 7;
      row = x >> 3;
    end else begin
      if (s == 2) x = (a & ~32'h44) | (((a >> 6) & 1) << 2) | (((a >> 2) & 1) << 6);
      bank = (x >> 3) & 3;
      if (s == 3) bank = bank ^ ((a >> 6) & 3);
      off = x & 7;
      row = x >> 5;
    end
  endfunction

  function automatic string rtag(input int s);
    case (s)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Called at a negedge; returns at a negedge two cycles later.
  task automatic run_vec(input int a, input int s);
    int eb, er, eo;
    ref_map(a, s, eb, er, eo);
    in_valid = 1'b1; in_scheme = 2'(s); in_addr = AW'(a);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R2", int'(out_valid), 1);
    chk(out_bank == BW'(eb), rtag(s), int'(out_bank), eb);
    chk(out_row == RW'(er) && out_off == POW'(eo), rtag(s),
        int'({out_row, out_off}), (er << 3) | eo);
    inv_valid = 1'b1; inv_scheme = 2'(s);
    inv_bank = BW'(eb); inv_row = RW'(er); inv_off = POW'(eo);
    @(negedge clk);
    inv_valid = 1'b0;
    chk(inv_vo == 1'b1, "R8", int'(inv_vo), 1);
    chk(inv_addr == AW'(a), "R9", int'(inv_addr), a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int b0, r0, o0;
    bit same;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(inv_vo == 1'b0, "R1", int'(inv_vo), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", int'(out_valid), 0);

    // Full sweep, every scheme, forward and round trip.
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < (1 << AW); a++) run_vec(a, s);

    // R7: whole page stays in one bank/row under permutation.
    same = 1'b1;
    for (int pg = 0; pg < (1 << (AW - POW)); pg += 37) begin
      run_vec(pg << POW, 3);
      b0 = int'(out_bank); r0 = int'(out_row);
      for (int o = 1; o < 8; o++) begin
        run_vec((pg << POW) | o, 3);
        if (int'(out_bank) != b0 || int'(out_row) != r0) same = 1'b0;
      end
    end
    chk(same, "R7", int'(same), 1);

    // R10/R2: scheme and address changes while idle leave outputs alone.
    run_vec(12'hA5C, 3);
    ref_map(12'hA5C, 3, b0, r0, o0);
    in_scheme = 2'd1; in_addr = 12'h3F0;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
    chk(out_bank == BW'(b0), "R10", int'(out_bank), b0);
    chk(out_row == RW'(r0) && out_off == POW'(o0), "R10",
        int'({out_row, out_off}), (r0 << 3) | o0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule